// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A single timer channel built around a down counter that runs either over its full 32 bits or over its low 16 bits only. The counter advances on ticks from a prescaler that divides the timer clock by 1, 16 or 256. Three behaviours at zero are available. Free-running wraps to all ones. Periodic reloads the stored load value. One-shot stops until software writes a new load value.

Software drives the block through a flat register port. It writes a control word, a load value that is pushed into the counter on the next tick, a background load value that takes effect only at the next reload, and an interrupt clear strobe. It reads back the control word, the load value, the live count and the raw and masked interrupt status. Each arrival at zero sets a sticky raw interrupt flag. The control word carries an enable bit that gates this flag onto a masked interrupt output. Everything runs in one clock domain.

Top module: `progDownTimer`

## Requirements
- R1: After reset, reading the control address (0) returns 0x40: disabled, free-running, 16-bit size, prescale select 00, interrupt enable set. The load address (1) reads 0, the value address (4) reads 0xFFFFFFFF, and the raw (5) and masked (6) status read 0.
- R2: The control word has these fields: enable bit 0, one-shot bit 1, periodic bit 2, 32-bit size bit 3, prescale select bits 5:4 and interrupt enable bit 6. One-shot set selects one-shot whatever the periodic bit holds. Periodic alone selects periodic. Neither bit selects free-running.
- R3: In free-running mode, a tick that finds the count at zero sets the raw interrupt and wraps the count to all ones: all 32 bits in 32-bit size, or the low 16 bits in 16-bit size. The load register value is not used.
- R4: In periodic mode, a tick that finds the count at zero sets the raw interrupt and copies the load register into the counter. Counting then continues.
- R5: In one-shot mode, a tick that finds the count at zero sets the raw interrupt and the count stays at zero. Counting resumes only after a write to the load address.
- R6: In 16-bit size, only the low 16 bits decrement and only they are tested for zero. The upper 16 bits keep their value.
- R7: A write to the load address (1) stores the value and restarts the prescaler. The value replaces the count at the first tick after the write, even while the counter is running.
- R8: A write to the background load address (2) updates the load register without touching the live count. The new value enters the counter at the next reload.
- R9: Prescale select 00 gives one tick per enabled clock, 01 one tick per 16 and 10 one tick per 256. Select 11 behaves like 00.
- R10: While the enable bit is clear, the count holds its value. After the bit is set again, counting resumes from that value.
- R11: A write to the clear address (3) clears the raw interrupt. If a zero event happens in the same cycle as the clear, the flag stays set.
- R12: The masked interrupt output and status read (6) equal the raw interrupt ANDed with the interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0 control, 1 load, 2 background load, 3 interrupt clear |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address: 0 control, 1 load, 4 value, 5 raw status, 6 masked status |
| rdData | output | 32 | Combinational read data, zero for unmapped addresses |
| irqRaw | output | 1 | Sticky raw interrupt |
| irqMasked | output | 1 | Raw interrupt gated by the interrupt-enable bit |

## Verification
Most internal faults surface through the readable count, within one tick of the cycle at fault. A stuck pending-load flag leaves the count one tick behind or skips a reload. A wrong mode decode writes all ones where the load value belongs, or the reverse, on the tick that finds zero. A halt flag that never clears freezes the count after the next load write. Prescaler faults appear only through the interrupt timing, as an arrival time that misses its expected count by a whole multiple of the divider. For that reason the divider cases are measured as exact cycle counts from the load write to the raw interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_LOAD   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_BGLOAD = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CLR    = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_VALUE  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_RAW    = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_MASKED = 3'd6;

  // Control word, LSB first: en, oneShot, periodic, wide, preSel, intEn
  typedef struct packed {
    logic       intEn;
    logic [1:0] preSel;
    logic       wide;
    logic       periodic;
    logic       oneShot;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadWr;
    logic bgWr;
    logic applyLoad;
    logic decrement;
    logic zeroHit;
    logic wrapAll;
    logic reloadFromLoad;
    logic halt;
    logic wide;
  } strobe_t;

endpackage

// File: rtl/tmrPrescaler.sv
module tmrPrescaler #(
  parameter int SHIFT_LO = 4,
  parameter int SHIFT_HI = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int PRE_W = SHIFT_HI;
  localparam logic [PRE_W-1:0] LIM_LO = PRE_W'((1 << SHIFT_LO) - 1);
  localparam logic [PRE_W-1:0] LIM_HI = {PRE_W{1'b1}};

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] limit;

  always_comb begin
    case (sel)
      2'b01:   limit = LIM_LO;
      2'b10:   limit = LIM_HI;
      default: limit = '0;   // 00 and 11 both divide by one
    endcase
  end

  assign tick = run && (preCnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      preCnt <= '0;
    end else if (run) begin
      preCnt <= tick ? '0 : preCnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/tmrCtrl.sv
module tmrCtrl
  import tmr_pkg::*;
#(
  parameter int SHIFT_LO = 4,
  parameter int SHIFT_HI = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic              atZero,
  output strobe_t           stb,
  output ctrl_t             ctrlWord,
  output logic              irqRaw
);
  localparam ctrl_t CTRL_RST = '{intEn: 1'b1, preSel: 2'b00, default: 1'b0};

  ctrl_t ctrlQ;
  logic  pending;
  logic  halted;
  logic  tick;
  logic  ctrlWr, loadWr, bgWr, clrWr;
  logic  freeMode, periodicMode, oneShotMode;
  logic  live;

  assign ctrlWr = wrEn && (wrAddr == ADR_CTRL);
  assign loadWr = wrEn && (wrAddr == ADR_LOAD);
  assign bgWr   = wrEn && (wrAddr == ADR_BGLOAD);
  assign clrWr  = wrEn && (wrAddr == ADR_CLR);

  // Mode decode: one-shot overrides the periodic bit
  assign oneShotMode  = ctrlQ.oneShot;
  assign periodicMode = !ctrlQ.oneShot && ctrlQ.periodic;
  assign freeMode     = !ctrlQ.oneShot && !ctrlQ.periodic;

  tmrPrescaler #(
    .SHIFT_LO(SHIFT_LO),
    .SHIFT_HI(SHIFT_HI)
  ) i_pre (
    .clk    (clk),
    .rstN   (rstN),
    .run    (ctrlQ.en),
    .restart(loadWr),
    .sel    (ctrlQ.preSel),
    .tick   (tick)
  );

  assign live = tick && !pending && !halted;

  always_comb begin
    stb                = '0;
    stb.loadWr         = loadWr;
    stb.bgWr           = bgWr;
    stb.wide           = ctrlQ.wide;
    stb.applyLoad      = tick && pending;
    stb.decrement      = live && !atZero;
    stb.zeroHit        = live && atZero;
    stb.wrapAll        = live && atZero && freeMode;
    stb.reloadFromLoad = live && atZero && periodicMode;
    stb.halt           = live && atZero && oneShotMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= CTRL_RST;
      pending <= 1'b0;
      halted  <= 1'b0;
      irqRaw  <= 1'b0;
    end else begin
      if (ctrlWr) ctrlQ <= ctrl_t'(ctrlData);

      if (loadWr)             pending <= 1'b1;
      else if (stb.applyLoad) pending <= 1'b0;

      if (loadWr)        halted <= 1'b0;
      else if (stb.halt) halted <= 1'b1;

      // a zero event in the same cycle beats the clear
      if (stb.zeroHit)    irqRaw <= 1'b1;
      else if (clrWr)     irqRaw <= 1'b0;
    end
  end

  assign ctrlWord = ctrlQ;
endmodule

// File: rtl/tmrDatapath.sv
module tmrDatapath
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] loadVal,
  output logic             atZero
);
  logic [CNT_W-1:0] count, loadReg, nextCount;
  logic [CNT_W-1:0] narrowDec, narrowWrap;

  // Narrow variant touches only the low half when the counter is wider
  generate
    if (CNT_W > HALF_W) begin : g_split
      assign narrowDec  = {count[CNT_W-1:HALF_W], count[HALF_W-1:0] - HALF_W'(1)};
      assign narrowWrap = {count[CNT_W-1:HALF_W], {HALF_W{1'b1}}};
    end else begin : g_flat
      assign narrowDec  = count - CNT_W'(1);
      assign narrowWrap = {CNT_W{1'b1}};
    end
  endgenerate

  assign atZero = stb.wide ? (count == '0) : (count[HALF_W-1:0] == '0);

  always_comb begin
    nextCount = count;
    if (stb.applyLoad || stb.reloadFromLoad) nextCount = loadReg;
    else if (stb.wrapAll)   nextCount = stb.wide ? {CNT_W{1'b1}} : narrowWrap;
    else if (stb.decrement) nextCount = stb.wide ? count - CNT_W'(1) : narrowDec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= {CNT_W{1'b1}};
      loadReg <= '0;
    end else begin
      count <= nextCount;
      if (stb.loadWr || stb.bgWr) loadReg <= wrData;
    end
  end

  assign countVal = count;
  assign loadVal  = loadReg;
endmodule

// File: rtl/progDownTimer.sv
module progDownTimer
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int HALF_W   = 16,
  parameter int SHIFT_LO = 4,
  parameter int SHIFT_HI = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              irqRaw,
  output logic              irqMasked
);
  strobe_t          stb;
  ctrl_t            ctrlWord;
  logic [CNT_W-1:0] countVal, loadVal;
  logic             atZero;
  logic             ctrlEn;

  tmrCtrl #(
    .SHIFT_LO(SHIFT_LO),
    .SHIFT_HI(SHIFT_HI)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .ctrlData(wrData[CTRL_W-1:0]),
    .atZero  (atZero),
    .stb     (stb),
    .ctrlWord(ctrlWord),
    .irqRaw  (irqRaw)
  );

  tmrDatapath #(
    .CNT_W (CNT_W),
    .HALF_W(HALF_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .countVal(countVal),
    .loadVal (loadVal),
    .atZero  (atZero)
  );

  assign ctrlEn    = ctrlWord.en;
  assign irqMasked = irqRaw && ctrlWord.intEn;

  always_comb begin
    case (rdAddr)
      ADR_CTRL:   rdData = CNT_W'(ctrlWord);
      ADR_LOAD:   rdData = loadVal;
      ADR_VALUE:  rdData = countVal;
      ADR_RAW:    rdData = CNT_W'(irqRaw);
      ADR_MASKED: rdData = CNT_W'(irqMasked);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/progDownTimerChecker.sv
module progDownTimerChecker
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input strobe_t           stb,
  input logic [CNT_W-1:0]  countVal,
  input logic              ctrlEn,
  input logic              irqRaw,
  input logic              irqMasked
);
  // R12: masked output never asserts without the raw flag
  p_mask_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    irqMasked |-> irqRaw);

  // R11: a clear with no coincident zero event drops the flag
  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADR_CLR && !stb.zeroHit) |=> !irqRaw);

  // R11: a zero event always leaves the flag set
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.zeroHit |=> irqRaw);

  // R6: narrow decrement leaves the upper half alone
  p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.decrement && !stb.wide) |=> $stable(countVal[CNT_W-1:HALF_W]));

  // R3: wide wrap lands on all ones
  p_wrap_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrapAll && stb.wide) |=> (countVal == {CNT_W{1'b1}}));

  // R5: one-shot stop keeps the counted field at zero
  p_halt_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.halt |=> (countVal[HALF_W-1:0] == '0));

  // R10: disabled counter does not move
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> $stable(countVal));
endmodule

bind progDownTimer progDownTimerChecker #(
  .CNT_W (CNT_W),
  .HALF_W(HALF_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .stb      (stb),
  .countVal (countVal),
  .ctrlEn   (ctrlEn),
  .irqRaw   (irqRaw),
  .irqMasked(irqMasked)
);

// File: tb/test_progDownTimer.sv
module test_progDownTimer;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_BG = 3'd2, A_CLR = 3'd3,
                         A_VAL = 3'd4, A_RAW = 3'd5, A_MSK = 3'd6;
  localparam logic [31:0] C_EN = 32'h01, C_OS = 32'h02, C_PER = 32'h04,
                          C_WIDE = 32'h08, C_INT = 32'h40;

  // Prescale table: select code, load value, cycles from load write to raw interrupt
  localparam int N_TBL = 4;
  localparam int unsigned TBL_SEL [N_TBL] = '{0, 1, 2, 3};
  localparam int unsigned TBL_LOAD[N_TBL] = '{5, 3, 1, 4};
  localparam int unsigned TBL_CYC [N_TBL] = '{7, 80, 768, 6};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irqRaw, irqMasked;

  int checks = 0;
  int failures = 0;
  int unsigned cyc = 0;
  bit done = 1'b0;

  progDownTimer i_progDownTimer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqRaw(irqRaw), .irqMasked(irqMasked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] v, v1;
    int unsigned t0;
    bit seen;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h40);
    rd(A_LOAD, v); chk("R1 load", v, 32'h0);
    rd(A_VAL, v);  chk("R1 value", v, 32'hFFFF_FFFF);
    rd(A_RAW, v);  chk("R1 raw", v, 32'h0);
    rd(A_MSK, v);  chk("R1 masked", v, 32'h0);

    // R9 prescale table walk, periodic wide mode
    for (int i = 0; i < N_TBL; i++) begin
      wr(A_CTRL, C_EN | C_PER | C_WIDE | C_INT | (TBL_SEL[i] << 4));
      wr(A_LOAD, TBL_LOAD[i]);
      t0 = cyc;
      wr(A_CLR, 32'h0);
      seen = 1'b0;
      for (int k = 0; k < 2000 && !seen; k++) begin
        @(negedge clk);
        if (irqRaw) seen = 1'b1;
      end
      chk($sformatf("R9 sel=%0d cycles", TBL_SEL[i]), cyc - t0, TBL_CYC[i]);
    end

    // R3 free-running 32-bit wrap ignores load
    wr(A_CTRL, C_EN | C_WIDE | C_INT);
    wr(A_LOAD, 32'd2);
    wr(A_CLR, 32'h0);
    edges(2);
    rd(A_VAL, v); chk("R3 at zero", v, 32'h0);
    chk("R3 no irq yet", {31'b0, irqRaw}, 32'h0);
    edges(1);
    rd(A_VAL, v); chk("R3 wrap", v, 32'hFFFF_FFFF);
    chk("R3 irq", {31'b0, irqRaw}, 32'h1);
    rd(A_LOAD, v); chk("R3 load kept", v, 32'd2);

    // R6 16-bit: only low half counted and tested
    wr(A_CTRL, C_EN | C_INT);
    wr(A_LOAD, 32'h1234_0001);
    wr(A_CLR, 32'h0);
    edges(1);
    rd(A_VAL, v); chk("R6 low zero", v, 32'h1234_0000);
    edges(1);
    chk("R6 irq", {31'b0, irqRaw}, 32'h1);
    rd(A_VAL, v); chk("R6 R3 narrow wrap", v, 32'h1234_FFFF);

    // R4 R8 periodic reload with background load
    wr(A_CTRL, C_EN | C_PER | C_WIDE | C_INT);
    wr(A_LOAD, 32'd3);
    wr(A_CLR, 32'h0);
    wr(A_BG, 32'd6);
    rd(A_VAL, v);  chk("R8 count untouched", v, 32'd2);
    rd(A_LOAD, v); chk("R8 load updated", v, 32'd6);
    edges(3);
    chk("R4 irq", {31'b0, irqRaw}, 32'h1);
    rd(A_VAL, v); chk("R4 R8 reload", v, 32'd6);

    // R5 R2 one-shot, periodic bit also set
    wr(A_CTRL, C_EN | C_OS | C_PER | C_WIDE | C_INT);
    wr(A_LOAD, 32'd1);
    wr(A_CLR, 32'h0);
    edges(2);
    chk("R5 irq", {31'b0, irqRaw}, 32'h1);
    rd(A_VAL, v); chk("R5 R2 stop", v, 32'h0);
    edges(5);
    rd(A_VAL, v); chk("R5 held", v, 32'h0);
    wr(A_CLR, 32'h0);
    edges(5);
    chk("R5 no refire", {31'b0, irqRaw}, 32'h0);
    wr(A_LOAD, 32'd2);
    edges(1);
    rd(A_VAL, v); chk("R5 restart", v, 32'd2);

    // R10 freeze and resume
    wr(A_CTRL, C_EN | C_PER | C_WIDE | C_INT);
    wr(A_LOAD, 32'd100);
    wr(A_CLR, 32'h0);
    edges(5);
    wr(A_CTRL, C_PER | C_WIDE | C_INT);
    rd(A_VAL, v1);
    edges(10);
    rd(A_VAL, v); chk("R10 frozen", v, v1);
    wr(A_CTRL, C_EN | C_PER | C_WIDE | C_INT);
    rd(A_VAL, v); chk("R10 no jump", v, v1);
    edges(1);
    rd(A_VAL, v); chk("R10 resume", v, v1 - 1);

    // R12 masking
    wr(A_CTRL, C_EN | C_WIDE);
    wr(A_LOAD, 32'd2);
    wr(A_CLR, 32'h0);
    edges(3);
    chk("R12 raw set", {31'b0, irqRaw}, 32'h1);
    chk("R12 masked off", {31'b0, irqMasked}, 32'h0);
    wr(A_CTRL, C_EN | C_WIDE | C_INT);
    chk("R12 masked on", {31'b0, irqMasked}, 32'h1);
    rd(A_MSK, v); chk("R12 masked read", v, 32'h1);

    // R11 set beats clear in the same cycle
    wr(A_LOAD, 32'd2);
    wr(A_CLR, 32'h0);
    repeat (2) @(posedge clk);
    wr(A_CLR, 32'h0);
    chk("R11 set wins", {31'b0, irqRaw}, 32'h1);
    wr(A_CLR, 32'h0);
    chk("R11 cleared", {31'b0, irqRaw}, 32'h0);

    // R7 load lands on first tick, prescaler restarted by the write
    wr(A_CTRL, C_EN | C_PER | C_WIDE | C_INT | 32'h10);
    wr(A_LOAD, 32'hABC);
    repeat (15) @(posedge clk);
    @(negedge clk);
    rd(A_VAL, v); chk("R7 not yet", {31'b0, (v == 32'hABC)}, 32'h0);
    edges(1);
    rd(A_VAL, v); chk("R7 loaded", v, 32'hABC);

    finishRun();
  end
endmodule